// File: doc/BRIEF.md
# SDRAM Single-Beat Read Sequencer

This block turns one host read request into the command stream an SDRAM needs to return the requested bytes, while the device mode stays fixed at a burst length of one. Each access opens the row with an activate command. The block then sends one individual column read per data beat on consecutive cycles, and only the final read carries auto-precharge. Returned beats are collected into a wide host buffer, lowest beat in the lowest bits. A one-cycle completion strobe marks the moment the buffer holds the whole transfer.

The external data bus can be 16 or 32 bits wide, and the width is chosen for each request. Access sizes run from a single byte up to a 128-byte line. The number of beats is the access size divided by the bus width, with a minimum of one. After the final beat arrives, the block holds the same bank idle for a programmable precharge recovery time of one to four cycles. A request to a different bank may still start during that window.

Top module: `sdr_burst_rd`

## Requirements
- R1: After synchronous reset, `sd_cmd` is 0 (no operation), `req_ready` is 1, `rd_done` is 0 and `rd_data` is all zeros.
- R2: The host byte address is split with the column in bits [9:0], the bank in bits [11:10] and the row in bits [24:12]. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle `sd_cmd` is 1 (activate), `sd_addr` carries the row and `sd_bank` carries the bank.
- R3: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 16 bytes and 4 = 128 bytes. The beat count is the byte count divided by 2 on the 16-bit bus or by 4 on the 32-bit bus, and never less than 1. This gives 1/1/2/8/64 beats on the 16-bit bus and 1/1/1/4/32 beats on the 32-bit bus.
- R4: The read commands start in the cycle right after the activate and run on consecutive cycles, one per beat. Every read except the last is code 2 (plain read). The last is code 3 (read with auto-precharge). The cycle after it is code 0.
- R5: The first read column is the request column with its low bit cleared (16-bit bus) or its low two bits cleared (32-bit bus). Each later read adds 2 or 4 to the column, modulo 1024. `sd_bank` does not change during the read train.
- R6: The beat for read k is sampled from `dq_in` two cycles after that read command. Beat k goes to `rd_data[k*32 +: 32]` on the 32-bit bus, or from `dq_in[15:0]` to `rd_data[k*16 +: 16]` on the 16-bit bus. Buffer bits beyond the transfer read as zero.
- R7: `rd_done` is high for exactly one cycle, three cycles after the auto-precharge read. In that cycle `rd_data` holds the full transfer, and it keeps that value until the next request is taken.
- R8: A precharge wait of `req_trp`+1 cycles begins in the `rd_done` cycle. During it, a request to the same bank is not taken. A same-bank request waiting from the `rd_done` cycle gets its activate `req_trp`+2 cycles after `rd_done`.
- R9: During the precharge wait, a request to a different bank is taken at once (`req_ready` high) and gets its activate in the next cycle.
- R10: From the activate to the last data beat, `req_ready` is low and requests are ignored, so no extra activate appears.
- R11: Size codes 5, 6 and 7 are handled as a one-beat access.
- R12: Size, bus width and wait setting are captured when a request is taken. Changing those inputs later has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host read request |
| req_addr | input | 25 | Host byte address {row, bank, column} |
| req_size | input | 3 | Access size code |
| req_bus32 | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| req_trp | input | 2 | Precharge wait setting, cycles minus one |
| req_ready | output | 1 | Request can be taken this cycle |
| sd_cmd | output | 2 | SDRAM command: 0 none, 1 activate, 2 read, 3 read with auto-precharge |
| sd_bank | output | 2 | SDRAM bank address |
| sd_addr | output | 13 | Row during activate, column during reads, else zero |
| dq_in | input | 32 | Read data from the SDRAM |
| rd_done | output | 1 | One-cycle completion strobe |
| rd_data | output | 1024 | Packed read buffer |

## Verification
The hardest case to reach is the short precharge window in which a request to another bank may overlap the recovery of the previous bank. It exists only after the last beat has landed and before the wait counter runs out. The bench gets there by issuing the second request in the cycle right after the completion strobe, with the longest wait setting. It also holds a same-bank request from the strobe cycle onward and measures the gap to its activate for the shortest and longest settings. Read trains run while the configuration inputs are scrambled and a stray request is held high.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_RDA = 2'd3
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_RD,
        ST_DRAIN,
        ST_TAP
    } seq_state_e;

    typedef struct packed {
        logic       bus32;
        logic [1:0] trp;
    } rd_cfg_t;

    function automatic logic [7:0] size_bytes(input logic [2:0] sz);
        case (sz)
            3'd1:    return 8'd2;
            3'd2:    return 8'd4;
            3'd3:    return 8'd16;
            3'd4:    return 8'd128;
            default: return 8'd1;
        endcase
    endfunction

    function automatic logic [7:0] beat_total(input logic [2:0] sz, input logic bus32);
        logic [7:0] b;
        b = bus32 ? (size_bytes(sz) >> 2) : (size_bytes(sz) >> 1);
        if (b == 8'd0) b = 8'd1;
        return b;
    endfunction

    function automatic logic [2:0] col_step(input logic bus32);
        return bus32 ? 3'd4 : 3'd2;
    endfunction

endpackage

// File: rtl/sdr_rd_ctrl.sv
module sdr_rd_ctrl
    import sdr_rd_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [BANK_W-1:0] cur_bank,
    input  logic [2:0]        req_size,
    input  rd_cfg_t           req_cfg,
    input  logic              drain_done,
    output logic              req_ready,
    output logic              accept,
    output logic              rd_issue,
    output logic              draining,
    output sdr_cmd_e          cmd,
    output rd_cfg_t           cfg_q
);

    seq_state_e       state_q;
    logic [CNT_W-1:0] left_q;
    logic [1:0]       tap_q;
    logic             wait_open;

    assign wait_open = (state_q == ST_TAP) && (req_bank != cur_bank);
    assign req_ready = (state_q == ST_IDLE) || wait_open;
    assign accept    = req_valid && req_ready;
    assign rd_issue  = (state_q == ST_RD);
    assign draining  = (state_q == ST_DRAIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            tap_q   <= '0;
            cfg_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_TAP: begin
                    if (accept) begin
                        state_q <= ST_ACT;
                        left_q  <= CNT_W'(beat_total(req_size, req_cfg.bus32));
                        cfg_q   <= req_cfg;
                    end else if (state_q == ST_TAP) begin
                        if (tap_q == 2'd0) state_q <= ST_IDLE;
                        else               tap_q   <= 2'(tap_q - 2'd1);
                    end
                end
                ST_ACT: state_q <= ST_RD;
                ST_RD: begin
                    left_q <= CNT_W'(left_q - 1'b1);
                    if (left_q == CNT_W'(1)) state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (drain_done) begin
                        state_q <= ST_TAP;
                        tap_q   <= cfg_q.trp;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ACT:  cmd = CMD_ACT;
            ST_RD:   cmd = (left_q == CNT_W'(1)) ? CMD_RDA : CMD_RD;
            default: cmd = CMD_NOP;
        endcase
    end

    assert_act_follows_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> cmd == CMD_ACT);
    assert_read_train_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT || cmd == CMD_RD) |=> (cmd == CMD_RD || cmd == CMD_RDA));
    assert_autopre_last_R4: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_RDA |=> cmd == CMD_NOP);
    assert_wait_other_bank_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAP && accept) |=> cur_bank != $past(cur_bank));
    assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACT || state_q == ST_RD || state_q == ST_DRAIN) |-> !req_ready);

endmodule

// File: rtl/sdr_rd_addr.sv
module sdr_rd_addr
    import sdr_rd_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int AO_W   = 13
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            accept,
    input  logic [ROW_W+BANK_W+COL_W-1:0]   req_addr,
    input  logic                            req_bus32,
    input  logic                            rd_issue,
    input  logic                            bus32_q,
    input  sdr_cmd_e                        cmd,
    output logic [AO_W-1:0]                 sd_addr,
    output logic [BANK_W-1:0]               sd_bank
);

    localparam int BANK_LO = COL_W;
    localparam int ROW_LO  = COL_W + BANK_W;

    logic [ROW_W-1:0]  row_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic [COL_W-1:0]  col_in;
    logic [COL_W-1:0]  col_base;
    logic [COL_W-1:0]  step;

    assign col_in   = req_addr[COL_W-1:0];
    assign col_base = req_bus32 ? (col_in & ~COL_W'(3)) : (col_in & ~COL_W'(1));
    assign step     = COL_W'(col_step(bus32_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= '0;
            bank_q <= '0;
            col_q  <= '0;
        end else if (accept) begin
            row_q  <= req_addr[ROW_LO +: ROW_W];
            bank_q <= req_addr[BANK_LO +: BANK_W];
            col_q  <= col_base;
        end else if (rd_issue) begin
            col_q  <= COL_W'(col_q + step);
        end
    end

    always_comb begin
        unique case (cmd)
            CMD_ACT:         sd_addr = AO_W'(row_q);
            CMD_RD, CMD_RDA: sd_addr = AO_W'(col_q);
            default:         sd_addr = '0;
        endcase
    end

    assign sd_bank = bank_q;

    assert_col_step_R5: assert property (@(posedge clk) disable iff (rst)
        ((cmd == CMD_RD || cmd == CMD_RDA) && $past(cmd) == CMD_RD)
        |-> sd_addr[COL_W-1:0] == COL_W'($past(sd_addr[COL_W-1:0]) + step));
    assert_bank_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD || cmd == CMD_RDA) |-> $stable(sd_bank));

endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
    parameter int CAS_LAT = 2,
    parameter int BUF_W   = 1024,
    parameter int CNT_W   = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             rd_issue,
    input  logic             bus32_q,
    input  logic             draining,
    input  logic [31:0]      dq_in,
    output logic             drain_done,
    output logic             done,
    output logic [BUF_W-1:0] data
);

    localparam int OFF_W = $clog2(BUF_W);

    logic [CAS_LAT-1:0] pipe_q;
    logic [CNT_W-1:0]   idx_q;
    logic [OFF_W-1:0]   off;
    logic               cap;

    assign cap        = pipe_q[CAS_LAT-1];
    assign drain_done = cap && (pipe_q[CAS_LAT-2:0] == '0);
    assign off        = bus32_q ? OFF_W'({idx_q, 5'b0}) : OFF_W'({idx_q, 4'b0});

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
            idx_q  <= '0;
            data   <= '0;
            done   <= 1'b0;
        end else begin
            pipe_q <= {pipe_q[CAS_LAT-2:0], rd_issue};
            done   <= draining && drain_done;
            if (accept) begin
                data  <= '0;
                idx_q <= '0;
            end else if (cap) begin
                if (bus32_q) data[off +: 32] <= dq_in;
                else         data[off +: 16] <= dq_in[15:0];
                idx_q <= CNT_W'(idx_q + 1'b1);
            end
        end
    end

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_clean_start_R6: assert property (@(posedge clk) disable iff (rst)
        accept |-> pipe_q == '0);

endmodule

// File: rtl/sdr_burst_rd.sv
module sdr_burst_rd
    import sdr_rd_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int BANK_W    = 2,
    parameter int COL_W     = 10,
    parameter int CAS_LAT   = 2,
    parameter int MAX_BYTES = 128,
    localparam int HOST_AW  = ROW_W + BANK_W + COL_W,
    localparam int AO_W     = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int BUF_W    = MAX_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [HOST_AW-1:0] req_addr,
    input  logic [2:0]         req_size,
    input  logic               req_bus32,
    input  logic [1:0]         req_trp,
    output logic               req_ready,
    output logic [1:0]         sd_cmd,
    output logic [BANK_W-1:0]  sd_bank,
    output logic [AO_W-1:0]    sd_addr,
    input  logic [31:0]        dq_in,
    output logic               rd_done,
    output logic [BUF_W-1:0]   rd_data
);

    localparam int CNT_W = $clog2(MAX_BYTES / 2) + 1;

    rd_cfg_t  req_cfg;
    rd_cfg_t  cfg_q;
    sdr_cmd_e cmd;
    logic     accept;
    logic     rd_issue;
    logic     draining;
    logic     drain_done;

    assign req_cfg = '{bus32: req_bus32, trp: req_trp};
    assign sd_cmd  = cmd;

    sdr_rd_ctrl #(.CNT_W(CNT_W), .BANK_W(BANK_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_bank   (req_addr[COL_W +: BANK_W]),
        .cur_bank   (sd_bank),
        .req_size   (req_size),
        .req_cfg    (req_cfg),
        .drain_done (drain_done),
        .req_ready  (req_ready),
        .accept     (accept),
        .rd_issue   (rd_issue),
        .draining   (draining),
        .cmd        (cmd),
        .cfg_q      (cfg_q)
    );

    sdr_rd_addr #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .AO_W(AO_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_bus32 (req_bus32),
        .rd_issue  (rd_issue),
        .bus32_q   (cfg_q.bus32),
        .cmd       (cmd),
        .sd_addr   (sd_addr),
        .sd_bank   (sd_bank)
    );

    sdr_rd_capture #(.CAS_LAT(CAS_LAT), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .rd_issue   (rd_issue),
        .bus32_q    (cfg_q.bus32),
        .draining   (draining),
        .dq_in      (dq_in),
        .drain_done (drain_done),
        .done       (rd_done),
        .data       (rd_data)
    );

endmodule

// File: tb/sdr_burst_rd_tb.sv
`timescale 1ns/1ps
module sdr_burst_rd_tb;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [24:0]   req_addr = '0;
    logic [2:0]    req_size = '0;
    logic          req_bus32 = 1'b0;
    logic [1:0]    req_trp = '0;
    logic          req_ready;
    logic [1:0]    sd_cmd;
    logic [1:0]    sd_bank;
    logic [12:0]   sd_addr;
    logic [31:0]   dq_in = '0;
    logic          rd_done;
    logic [1023:0] rd_data;

    int            errors = 0;
    int            checks = 0;
    bit            reported = 0;
    logic [1023:0] last_exp = '0;

    always #2.5 clk = ~clk;

    sdr_burst_rd u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_bus32(req_bus32), .req_trp(req_trp),
        .req_ready(req_ready), .sd_cmd(sd_cmd), .sd_bank(sd_bank),
        .sd_addr(sd_addr), .dq_in(dq_in), .rd_done(rd_done), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [1023:0] act,
                       input logic [1023:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    endtask

    function automatic logic [24:0] mk(input int row, input int bank, input int col);
        return {13'(row), 2'(bank), 10'(col)};
    endfunction

    function automatic int exp_beats(input logic [2:0] sz, input logic b32);
        int by;
        int b;
        case (sz)
            3'd1: by = 2;
            3'd2: by = 4;
            3'd3: by = 16;
            3'd4: by = 128;
            default: by = 1;
        endcase
        b = b32 ? by / 4 : by / 2;
        return (b < 1) ? 1 : b;
    endfunction

    function automatic logic [31:0] pat(input logic [7:0] seed, input int j);
        return {seed, 8'(j), 8'(j + int'(seed)), ~8'(j)};
    endfunction

    task automatic run_read(input logic [24:0] addr, input logic [2:0] sz, input logic b32,
                            input logic [1:0] trp, input logic [7:0] seed, input bit hold,
                            input string tag);
        int            n;
        int            step;
        logic [9:0]    col0;
        logic [1023:0] exp;
        logic [31:0]   p;
        n    = exp_beats(sz, b32);
        step = b32 ? 4 : 2;
        col0 = addr[9:0] & (b32 ? 10'h3FC : 10'h3FE);
        exp  = '0;
        for (int j = 0; j < n; j++) begin
            p = pat(seed, j);
            if (b32) exp[j*32 +: 32] = p;
            else     exp[j*16 +: 16] = p[15:0];
        end
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_size = sz; req_bus32 = b32; req_trp = trp;
        #1;
        chk(req_ready === 1'b1, {"R2/R9 ready to take ", tag}, 1024'(req_ready), 1);
        for (int c = 0; c <= n + 3; c++) begin
            @(negedge clk);
            req_valid = hold && (c <= n + 2);
            req_addr  = {~addr[24:12], addr[11:0]};
            req_size  = ~sz; req_bus32 = ~b32; req_trp = ~trp;
            dq_in     = (c >= 3 && c - 3 < n) ? pat(seed, c - 3) : (32'hA5A5_0000 | 32'(c));
            #1;
            if (c == 0) begin
                chk(sd_cmd == 2'd1, {"R2 activate ", tag}, 1024'(sd_cmd), 1);
                chk(sd_addr == addr[24:12], {"R2 row ", tag}, 1024'(sd_addr), 1024'(addr[24:12]));
                chk(sd_bank == addr[11:10], {"R2 bank ", tag}, 1024'(sd_bank), 1024'(addr[11:10]));
            end else if (c <= n) begin
                chk(sd_cmd == ((c == n) ? 2'd3 : 2'd2), {"R3/R4/R12 read command ", tag},
                    1024'(sd_cmd), (c == n) ? 3 : 2);
                chk(sd_addr == {3'b0, 10'(col0 + 10'(step * (c - 1)))}, {"R5 column ", tag},
                    1024'(sd_addr), 1024'(10'(col0 + 10'(step * (c - 1)))));
                chk(sd_bank == addr[11:10], {"R5 bank held ", tag}, 1024'(sd_bank), 1024'(addr[11:10]));
            end else begin
                chk(sd_cmd == 2'd0, {"R4 idle after last read ", tag}, 1024'(sd_cmd), 0);
            end
            if (hold && c <= n + 2)
                chk(req_ready == 1'b0, {"R10 busy ", tag}, 1024'(req_ready), 0);
            chk(rd_done == (c == n + 3), {"R7 done strobe ", tag}, 1024'(rd_done), 1024'(c == n + 3));
            if (c == n + 3)
                chk(rd_data == exp, {"R6 packed data ", tag}, rd_data, exp);
        end
        req_valid = 1'b0;
        last_exp  = exp;
    endtask

    task automatic settle(input bit data_kept);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        #1;
        chk(sd_cmd == 2'd0 && req_ready == 1'b1, "R1 back to idle", 1024'({sd_cmd, req_ready}), 1);
        if (data_kept)
            chk(rd_data == last_exp, "R7 data held", rd_data, last_exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(sd_cmd == 2'd0, "R1 reset command", 1024'(sd_cmd), 0);
        chk(req_ready == 1'b1, "R1 reset ready", 1024'(req_ready), 1);
        chk(rd_done == 1'b0, "R1 reset done", 1024'(rd_done), 0);
        chk(rd_data == '0, "R1 reset data", rd_data, 0);
    endtask

    task automatic t_wait_same_bank(input logic [1:0] trp);
        int k;
        bit found;
        run_read(mk(100, 1, 40), 3'd2, 1'b1, trp, 8'h5C, 0, "R8 lead");
        req_valid = 1'b1; req_addr = mk(200, 1, 8); req_size = 3'd0; req_bus32 = 1'b1; req_trp = 2'd0;
        #1;
        chk(req_ready == 1'b0, "R8 same bank held off", 1024'(req_ready), 0);
        k = 0; found = 0;
        for (int i = 1; i <= 8 && !found; i++) begin
            @(negedge clk);
            #1;
            if (sd_cmd == 2'd1) begin found = 1; k = i; end
        end
        req_valid = 1'b0;
        chk(k == int'(trp) + 2, "R8 wait length", 1024'(k), 1024'(int'(trp) + 2));
        settle(0);
    endtask

    task automatic t_wait_other_bank();
        run_read(mk(300, 0, 16), 3'd3, 1'b1, 2'd3, 8'h3E, 0, "R9 first");
        run_read(mk(301, 2, 64), 3'd2, 1'b0, 2'd0, 8'h71, 0, "R9 other bank");
        settle(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        t_reset();
        run_read(mk(5, 0, 3),    3'd0, 1'b0, 2'd0, 8'h11, 0, "R3 byte bus16");
        settle(1);
        run_read(mk(6, 1, 10),   3'd2, 1'b0, 2'd1, 8'h22, 1, "R3 word bus16");
        settle(1);
        run_read(mk(7, 2, 21),   3'd2, 1'b1, 2'd2, 8'h33, 0, "R3 word bus32");
        settle(1);
        run_read(mk(8, 3, 32),   3'd3, 1'b0, 2'd0, 8'h44, 1, "R3 line16 bus16");
        settle(1);
        run_read(mk(9, 0, 1018), 3'd3, 1'b1, 2'd3, 8'h55, 0, "R5 line16 bus32 wrap");
        settle(1);
        run_read(mk(10, 1, 0),   3'd4, 1'b1, 2'd1, 8'h66, 1, "R3 line128 bus32");
        settle(1);
        run_read(mk(11, 2, 128), 3'd4, 1'b0, 2'd2, 8'h77, 0, "R3 line128 bus16");
        settle(1);
        run_read(mk(12, 3, 7),   3'd6, 1'b1, 2'd0, 8'h88, 0, "R11 code6 bus32");
        settle(1);
        run_read(mk(13, 0, 15),  3'd1, 1'b1, 2'd0, 8'h99, 0, "R5 half bus32 odd column");
        settle(1);
        t_wait_same_bank(2'd0);
        t_wait_same_bank(2'd3);
        t_wait_other_bank();
        report();
    end

endmodule